// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block is the bus-facing half of a SPI host controller. It answers 32-bit word accesses inside a 4 KiB window: it holds the configuration words, a byte queue for outgoing data and a byte queue for incoming data, and it drives the chip-select lines and one interrupt line. The serial clock, bit shifting and delay timing are out of scope. Bytes leave through a byte-exchange port. The port takes one transmit byte per request and returns exactly one received byte per request.

Software writes bytes to the transmit data word. The block forwards queued bytes one at a time over the exchange port and keeps the returned bytes unless receive is switched off. Software then reads them back from the receive data word. Queue full and queue empty are reported in bit 31 of the two data words. Two watermark comparisons against the live queue fill levels form the pending bits. The enable word gates those bits onto the interrupt line. A configuration write with an out-of-range value is dropped as a whole.

Top module: `spi_host_regif`

## Requirements
- R1: After reset, the clock divider (0x00) reads 0x3, delay0 (0x28) reads 0x1001 and delay1 (0x2C) reads 0x1. CS default (0x14) reads all ones in its NUM_CS low bits, and every other word reads zero. Both queues are empty and irq is low.
- R2: A read of a reserved offset or of any offset at or above 0x78 returns zero. A write to such an offset changes nothing.
- R3: A read of the transmit data word (0x48) returns 0x8000_0000 when the transmit queue holds 8 bytes, and zero otherwise.
- R4: A read of the receive data word (0x4C) returns 0x8000_0000 when the receive queue is empty. Otherwise it removes the oldest byte and returns it in bits 7:0, with the upper bits zero.
- R5: A write to 0x48 queues wdata[7:0] when the transmit queue is not full. When the queue is full the byte is lost.
- R6: The exchange request xfer_valid presents the oldest queued byte on xfer_tx and holds it until xfer_ready. Only one exchange is outstanding. The next request rises in the cycle after xfer_done.
- R7: A byte returned on xfer_done is queued only when the receive queue is not full and bit 3 of the frame format word (0x40) is 0. Otherwise it is dropped.
- R8: The pending word (0x74) has bit 0 set while the transmit fill is below the tx mark (0x50), and bit 1 set while the receive fill is above the rx mark (0x54). Writes to 0x74 and to 0x4C change nothing.
- R9: irq is high exactly when some bit of pending AND enable (0x70, bit 0 transmit, bit 1 receive) is set.
- R10: A write of 8 or more to the tx mark or the rx mark is dropped, and the old value is kept.
- R11: A write to CS mode (0x18) above 3 is dropped. A write to CS id (0x10) of NUM_CS or more is dropped. A write to CS default of 2^NUM_CS or more is dropped.
- R12: cs_o[i] is high when bit i of CS default is set and CS mode is 0. It is low otherwise.
- R13: Writes to the flash control word (0x60) and the flash format word (0x64) are ignored, and both words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the cycle of the access |
| xfer_valid | output | 1 | Exchange request |
| xfer_ready | input | 1 | Exchange request accepted |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | One-cycle pulse: exchange finished |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |
| cs_o | output | NUM_CS | Chip-select levels |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so it is due in the cycle of the access. The bench samples it 1 ns after the falling edge, before the rising edge that performs any pop. A push, a pop or a configuration write takes effect at that rising edge. The resulting queue flags, pending bits, cs_o and irq are therefore checked from the next access cycle onward. A byte takes about four cycles to pass from handshake through done to the receive queue, so the bench waits a fixed generous number of cycles after each burst before it counts handshakes or reads back bytes.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
    localparam logic [11:0] OFS_CLKDIV  = 12'h000;
    localparam logic [11:0] OFS_CLKMODE = 12'h004;
    localparam logic [11:0] OFS_CSSEL   = 12'h010;
    localparam logic [11:0] OFS_CSDFLT  = 12'h014;
    localparam logic [11:0] OFS_CSCTL   = 12'h018;
    localparam logic [11:0] OFS_GAP0    = 12'h028;
    localparam logic [11:0] OFS_GAP1    = 12'h02C;
    localparam logic [11:0] OFS_FRAME   = 12'h040;
    localparam logic [11:0] OFS_TXBYTE  = 12'h048;
    localparam logic [11:0] OFS_RXBYTE  = 12'h04C;
    localparam logic [11:0] OFS_TXLVL   = 12'h050;
    localparam logic [11:0] OFS_RXLVL   = 12'h054;
    localparam logic [11:0] OFS_INTEN   = 12'h070;
    localparam logic [11:0] OFS_INTPEND = 12'h074;

    localparam logic [31:0] FLAG_B31    = 32'h8000_0000;
    localparam int          FRAME_RXOFF = 3;

    typedef enum logic [0:0] {
        XS_IDLE = 1'b0,
        XS_WAIT = 1'b1
    } xstate_e;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_xchg_engine.sv
module spi_xchg_engine
    import spi_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_empty,
    input  logic [7:0] tx_head,
    output logic       tx_pop,
    input  logic       rx_full,
    input  logic       rx_off,
    output logic       rx_push,
    output logic [7:0] rx_byte,
    output logic       xfer_valid,
    input  logic       xfer_ready,
    output logic [7:0] xfer_tx,
    input  logic       xfer_done,
    input  logic [7:0] xfer_rx
);
    typedef struct packed {
        xstate_e st;
    } eng_st_t;

    eng_st_t e_d, e_q;

    assign xfer_valid = (e_q.st == XS_IDLE) && !tx_empty;
    assign xfer_tx    = tx_head;
    assign tx_pop     = xfer_valid && xfer_ready;
    assign rx_push    = (e_q.st == XS_WAIT) && xfer_done && !rx_full && !rx_off;
    assign rx_byte    = xfer_rx;

    always_comb begin
        e_d = e_q;
        case (e_q.st)
            XS_IDLE: if (tx_pop)    e_d.st = XS_WAIT;
            XS_WAIT: if (xfer_done) e_d.st = XS_IDLE;
            default: e_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '{st: XS_IDLE};
        else        e_q <= e_d;
    end
endmodule

// File: rtl/spi_host_regif.sv
module spi_host_regif
    import spi_regif_pkg::*;
#(
    parameter int NUM_CS     = 2,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_done,
    input  logic [7:0]        xfer_rx,
    output logic [NUM_CS-1:0] cs_o,
    output logic              irq
);
    localparam int CSID_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam int MW     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
    localparam int CW     = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [31:0]       clkdiv;
        logic [31:0]       clkmode;
        logic [31:0]       gap0;
        logic [31:0]       gap1;
        logic [31:0]       frame;
        logic [CSID_W-1:0] cssel;
        logic [NUM_CS-1:0] csdflt;
        logic [1:0]        csctl;
        logic [MW-1:0]     txlvl;
        logic [MW-1:0]     rxlvl;
        logic [1:0]        inten;
    } regs_t;

    regs_t regs_d, regs_q;

    logic          rd_en, wr_en;
    logic          tx_push, tx_pop, rx_push, rx_pop;
    logic [7:0]    tx_head, rx_head, rx_byte;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_pend, rx_pend;
    logic [1:0]    pend;
    logic [1:0]    inten_cur;
    logic          rxoff_cur;

    assign rd_en     = req_valid && !req_write;
    assign wr_en     = req_valid && req_write;
    assign tx_push   = wr_en && (req_addr == OFS_TXBYTE);
    assign rx_pop    = rd_en && (req_addr == OFS_RXBYTE);
    assign inten_cur = regs_q.inten;
    assign rxoff_cur = regs_q.frame[FRAME_RXOFF];

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(req_wdata[7:0]),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_byte),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    spi_xchg_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_off(rxoff_cur),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx)
    );

    assign tx_pend = tx_cnt < CW'(regs_q.txlvl);
    assign rx_pend = rx_cnt > CW'(regs_q.rxlvl);
    assign pend    = {rx_pend, tx_pend};
    assign irq     = |(pend & regs_q.inten);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_o[i] = regs_q.csdflt[i] && (regs_q.csctl == 2'd0);
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (req_addr)
                OFS_CLKDIV:  regs_d.clkdiv  = req_wdata;
                OFS_CLKMODE: regs_d.clkmode = req_wdata;
                OFS_GAP0:    regs_d.gap0    = req_wdata;
                OFS_GAP1:    regs_d.gap1    = req_wdata;
                OFS_FRAME:   regs_d.frame   = req_wdata;
                OFS_INTEN:   regs_d.inten   = req_wdata[1:0];
                OFS_CSSEL:
                    if (req_wdata < 32'(NUM_CS))
                        regs_d.cssel = req_wdata[CSID_W-1:0];
                OFS_CSDFLT:
                    if (req_wdata < (32'd1 << NUM_CS))
                        regs_d.csdflt = req_wdata[NUM_CS-1:0];
                OFS_CSCTL:
                    if (req_wdata < 32'd4)
                        regs_d.csctl = req_wdata[1:0];
                OFS_TXLVL:
                    if (req_wdata < 32'(FIFO_DEPTH))
                        regs_d.txlvl = req_wdata[MW-1:0];
                OFS_RXLVL:
                    if (req_wdata < 32'(FIFO_DEPTH))
                        regs_d.rxlvl = req_wdata[MW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rsp_rdata = '0;
        if (rd_en) begin
            case (req_addr)
                OFS_CLKDIV:  rsp_rdata = regs_q.clkdiv;
                OFS_CLKMODE: rsp_rdata = regs_q.clkmode;
                OFS_GAP0:    rsp_rdata = regs_q.gap0;
                OFS_GAP1:    rsp_rdata = regs_q.gap1;
                OFS_FRAME:   rsp_rdata = regs_q.frame;
                OFS_INTEN:   rsp_rdata = 32'(regs_q.inten);
                OFS_CSSEL:   rsp_rdata = 32'(regs_q.cssel);
                OFS_CSDFLT:  rsp_rdata = 32'(regs_q.csdflt);
                OFS_CSCTL:   rsp_rdata = 32'(regs_q.csctl);
                OFS_TXLVL:   rsp_rdata = 32'(regs_q.txlvl);
                OFS_RXLVL:   rsp_rdata = 32'(regs_q.rxlvl);
                OFS_INTPEND: rsp_rdata = 32'(pend);
                OFS_TXBYTE:  rsp_rdata = tx_full ? FLAG_B31 : 32'd0;
                OFS_RXBYTE:  rsp_rdata = rx_empty ? FLAG_B31 : {24'd0, rx_head};
                default:     rsp_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q        <= '0;
            regs_q.clkdiv <= 32'h3;
            regs_q.gap0   <= 32'h1001;
            regs_q.gap1   <= 32'h1;
            regs_q.csdflt <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/spi_host_regif_chk.sv
module spi_host_regif_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [11:0]   req_addr,
    input logic [31:0]   rsp_rdata,
    input logic          xfer_valid,
    input logic          xfer_ready,
    input logic          xfer_done,
    input logic          irq,
    input logic [1:0]    inten,
    input logic          rxoff,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt
);
    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_ready |=> !xfer_valid);

    a_r5_tx_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));

    a_r7_rxoff_discards: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && rxoff |=> rx_cnt <= $past(rx_cnt));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> inten != 2'b00);

    a_r2_far_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_addr >= 12'h078 |-> rsp_rdata == 32'd0);

    a_r4_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_addr == 12'h04C && rx_cnt == '0
        |-> rsp_rdata == 32'h8000_0000);
endmodule

bind spi_host_regif spi_host_regif_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .rsp_rdata(rsp_rdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_done(xfer_done),
    .irq(irq), .inten(inten_cur), .rxoff(rxoff_cur),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_host_regif_tb.sv
`timescale 1ns/1ps
module spi_host_regif_tb;
    localparam int NCS = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]    req_addr = '0;
    logic [31:0]    req_wdata = '0;
    logic [31:0]    rsp_rdata;
    logic           xfer_valid, xfer_ready = 1'b0;
    logic [7:0]     xfer_tx;
    logic           xfer_done = 1'b0;
    logic [7:0]     xfer_rx = '0;
    logic [NCS-1:0] cs_o;
    logic           irq;

    int total = 0;
    int bad   = 0;
    int hs_cnt = 0;
    logic [7:0] hs_log [0:31];
    logic [7:0] rsp_byte = '0;
    int rsp_dly = 0;

    always #2.5 clk = ~clk;

    spi_host_regif #(.NUM_CS(NCS), .FIFO_DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx),
        .cs_o(cs_o), .irq(irq)
    );

    // Remote device model: answers each accepted byte two cycles later with byte ^ 0x5A.
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (xfer_valid && xfer_ready) begin
            hs_log[hs_cnt[4:0]] <= xfer_tx;
            hs_cnt   <= hs_cnt + 1;
            rsp_byte <= xfer_tx ^ 8'h5A;
            rsp_dly  <= 2;
        end else if (rsp_dly == 1) begin
            xfer_done <= 1'b1;
            xfer_rx   <= rsp_byte;
            rsp_dly   <= 0;
        end else if (rsp_dly != 0) begin
            rsp_dly <= rsp_dly - 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic irq_seen);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        rd = rsp_rdata;
        irq_seen = irq;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] r; logic q;
        access(1'b1, a, d, r, q);
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] r; logic q;
        access(1'b0, a, 32'd0, r, q);
        check(tag, r, exp);
    endtask

    task automatic port_chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        @(negedge clk);
        #1;
        check(tag, act, exp);
    endtask

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        irq;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 12'h000, 32'h0, 32'h3,         1'b0}, // R1 divider
        '{1'b0, 12'h028, 32'h0, 32'h1001,      1'b0}, // R1 delay0
        '{1'b0, 12'h02C, 32'h0, 32'h1,         1'b0}, // R1 delay1
        '{1'b0, 12'h014, 32'h0, 32'h3,         1'b0}, // R1 cs default
        '{1'b0, 12'h04C, 32'h0, 32'h8000_0000, 1'b0}, // R1 rx empty
        '{1'b0, 12'h048, 32'h0, 32'h0,         1'b0}, // R3 not full
        '{1'b1, 12'h008, 32'hFFFF, 32'h0,      1'b0}, // R2 reserved write
        '{1'b0, 12'h008, 32'h0, 32'h0,         1'b0}, // R2 reserved read
        '{1'b1, 12'h100, 32'h7, 32'h0,         1'b0}, // R2 far write
        '{1'b0, 12'h100, 32'h0, 32'h0,         1'b0}, // R2 far read
        '{1'b1, 12'h050, 32'h9, 32'h0,         1'b0}, // R10 reject
        '{1'b0, 12'h050, 32'h0, 32'h0,         1'b0}, // R10 kept
        '{1'b1, 12'h054, 32'h8, 32'h0,         1'b0}, // R10 reject rx
        '{1'b0, 12'h054, 32'h0, 32'h0,         1'b0}, // R10 kept rx
        '{1'b1, 12'h050, 32'h5, 32'h0,         1'b0}, // R10 accept
        '{1'b0, 12'h050, 32'h0, 32'h5,         1'b0}, // R10 readback
        '{1'b0, 12'h074, 32'h0, 32'h1,         1'b0}, // R8 tx pending
        '{1'b1, 12'h070, 32'h1, 32'h0,         1'b0}, // R9 enable tx
        '{1'b0, 12'h070, 32'h0, 32'h1,         1'b1}, // R9 irq high
        '{1'b1, 12'h074, 32'h0, 32'h0,         1'b1}, // R8 pending read-only
        '{1'b0, 12'h074, 32'h0, 32'h1,         1'b1}, // R8 unchanged
        '{1'b1, 12'h018, 32'h4, 32'h0,         1'b1}, // R11 csmode reject
        '{1'b0, 12'h018, 32'h0, 32'h0,         1'b1}, // R11 kept
        '{1'b1, 12'h010, 32'h2, 32'h0,         1'b1}, // R11 csid reject
        '{1'b0, 12'h010, 32'h0, 32'h0,         1'b1}, // R11 kept
        '{1'b1, 12'h010, 32'h1, 32'h0,         1'b1}, // R11 csid accept
        '{1'b0, 12'h010, 32'h0, 32'h1,         1'b1}, // R11 readback
        '{1'b1, 12'h014, 32'h4, 32'h0,         1'b1}, // R11 csdef reject
        '{1'b0, 12'h014, 32'h0, 32'h3,         1'b1}, // R11 kept
        '{1'b1, 12'h060, 32'h5, 32'h0,         1'b1}  // R13 flash write
    };

    initial begin
        logic [31:0] r;
        logic        q;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        port_chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            access(VEC[k].wr, VEC[k].addr, VEC[k].data, r, q);
            if (!VEC[k].wr) check($sformatf("R1..R13 vector %0d rdata", k), r, VEC[k].exp);
            check($sformatf("R9 vector %0d irq", k), {31'd0, q}, {31'd0, VEC[k].irq});
        end

        rd_chk("R13 flash ctrl reads zero", 12'h060, 32'd0);
        wr32(12'h064, 32'hF);
        rd_chk("R13 flash fmt reads zero", 12'h064, 32'd0);

        // R12 chip selects
        wr32(12'h014, 32'h1);
        wr32(12'h018, 32'h2);
        port_chk("R12 cs low in mode 2", 32'(cs_o), 32'h0);
        wr32(12'h018, 32'h0);
        port_chk("R12 cs follows default", 32'(cs_o), 32'h1);

        // Fill the transmit queue while the port is stalled
        for (int k = 0; k < 8; k++) wr32(12'h048, 32'h11 + k);
        wr32(12'h048, 32'h99);
        rd_chk("R3 tx full flag", 12'h048, 32'h8000_0000);
        port_chk("R6 valid held", {31'd0, xfer_valid}, 32'd1);
        port_chk("R6 head byte", 32'(xfer_tx), 32'h11);
        rd_chk("R8 pending clear at full", 12'h074, 32'h0);
        port_chk("R9 irq low", {31'd0, irq}, 32'd0);

        xfer_ready = 1'b1;
        repeat (60) @(posedge clk);
        port_chk("R5 overflow byte dropped", 32'(hs_cnt), 32'd8);
        for (int k = 0; k < 8; k++)
            check("R6 send order", 32'(hs_log[k]), 32'h11 + k);

        wr32(12'h048, 32'hAA);
        repeat (20) @(posedge clk);
        port_chk("R7 ninth byte exchanged", 32'(hs_cnt), 32'd9);

        wr32(12'h054, 32'h2);
        wr32(12'h070, 32'h2);
        port_chk("R9 rx irq", {31'd0, irq}, 32'd1);
        rd_chk("R8 both pending", 12'h074, 32'h3);
        for (int k = 0; k < 8; k++)
            rd_chk("R4 rx order", 12'h04C, (32'h11 + k) ^ 32'h5A);
        rd_chk("R7 full-queue byte dropped", 12'h04C, 32'h8000_0000);
        port_chk("R9 irq drops after drain", {31'd0, irq}, 32'd0);

        wr32(12'h040, 32'h8);
        rd_chk("R7 frame readback", 12'h040, 32'h8);
        wr32(12'h048, 32'h33);
        repeat (20) @(posedge clk);
        port_chk("R7 rx-off byte exchanged", 32'(hs_cnt), 32'd10);
        rd_chk("R7 rx-off byte dropped", 12'h04C, 32'h8000_0000);
        wr32(12'h04C, 32'h77);
        rd_chk("R8 rx data read-only", 12'h04C, 32'h8000_0000);

        // Reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        rd_chk("R1 divider after reset", 12'h000, 32'h3);
        rd_chk("R1 tx mark after reset", 12'h050, 32'h0);
        rd_chk("R1 frame after reset", 12'h040, 32'h0);
        port_chk("R1 cs after reset", 32'(cs_o), 32'h3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule